// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block is the directory controller of one home cluster in a coherent memory system built from several clusters. For every line of the small memory it owns, it keeps a line state (Uncached, Shared or Modified) and a presence vector with one bit per cluster. Clusters send it read and read-exclusive requests. The directory answers each request in one of three ways. It can grant the memory word at once. It can send invalidates to the other holders and grant the word once all of them have acknowledged. It can name the cluster that owns a Modified line and forward the request to that owner.

Each line always has exactly one owner. The home owns Uncached and Shared lines, and the single marked cluster owns a Modified line. Ownership moves through invalidation and forwarding. Only one transaction is open at a time. While it is open, any new request is bounced with a retry indication. A voluntary writeback from the owner returns a line to memory.

Top module: `dir_home`

## Requirements
- R1: After reset every line is Uncached with an empty presence vector and holds the word 32'hC0DE_0000 plus its line index; no grant, retry or message output is valid.
- R2: A read (req_kind 0) of an Uncached or Shared line is granted in the next cycle with grant_kind 0 (data) and the memory word; the line becomes Shared with the requester's presence bit added.
- R3: A read-exclusive (req_kind 1) of a line that is Uncached, or Shared with no holder other than the requester, is granted data in the next cycle; the line becomes Modified with the requester as sole owner.
- R4: A read-exclusive of a Shared line with other holders emits, in the next cycle, one message of msg_kind 0 (invalidate) whose msg_mask is exactly those other holders, and no grant. The data grant to the requester appears in the cycle in which the last awaited acknowledgement is accepted, and the line then becomes Modified and owned by the requester.
- R5: A request from a non-owner to a Modified line is answered in the next cycle with grant_kind 1 (owner) naming the owner in grant_owner, together with a message to the owner alone: msg_kind 1 for a read, 2 for a read-exclusive, and msg_req naming the requester.
- R6: When the owner acknowledges a forwarded read, its ack_data is written to memory, and the line becomes Shared with both the old owner and the requester marked.
- R7: When the owner acknowledges a forwarded read-exclusive, the line stays Modified with the requester as the new owner. Neither forward completion produces a grant.
- R8: A request that arrives while a transaction is open, or in the same cycle as a writeback input, is answered in the next cycle with retry_valid and retry_dst set to the requester, and it changes no line.
- R9: A writeback from the owner of a Modified line while no transaction is open stores wb_data, and the line becomes Uncached with an empty presence vector.
- R10: A writeback from a cluster that does not own the line, or to a line that is not Modified, changes nothing.
- R11: An acknowledgement from a cluster whose acknowledgement is not awaited is ignored.
- R12: A request from the owner of a Modified line is answered in the next cycle with grant_kind 1 naming that owner, with no message and no open transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 1 | 0 read, 1 read-exclusive |
| req_src | input | $clog2(NUM_CLUSTERS) | Requesting cluster |
| req_line | input | $clog2(NUM_LINES) | Requested line |
| ack_valid | input | 1 | Acknowledgement present |
| ack_src | input | $clog2(NUM_CLUSTERS) | Acknowledging cluster |
| ack_data | input | DATA_W | Line word returned by an owner on a forwarded read |
| wb_valid | input | 1 | Voluntary writeback present |
| wb_src | input | $clog2(NUM_CLUSTERS) | Writing-back cluster |
| wb_line | input | $clog2(NUM_LINES) | Written-back line |
| wb_data | input | DATA_W | Written-back word |
| grant_valid | output | 1 | Grant response valid |
| grant_kind | output | 1 | 0 data, 1 owner identity |
| grant_dst | output | $clog2(NUM_CLUSTERS) | Cluster receiving the grant |
| grant_owner | output | $clog2(NUM_CLUSTERS) | Owner named by an owner grant, else 0 |
| grant_data | output | DATA_W | Memory word for a data grant |
| retry_valid | output | 1 | Retry response valid |
| retry_dst | output | $clog2(NUM_CLUSTERS) | Cluster told to retry |
| msg_valid | output | 1 | Coherence message valid |
| msg_kind | output | 2 | 0 invalidate, 1 forward read, 2 forward exclusive |
| msg_mask | output | NUM_CLUSTERS | Clusters addressed by the message |
| msg_line | output | $clog2(NUM_LINES) | Line concerned |
| msg_req | output | $clog2(NUM_CLUSTERS) | Cluster that made the request |

## Verification
Several rules are checked by assertions on every cycle. A line written as Modified has exactly one presence bit, and a line written as Uncached has none. An invalidate never targets its own requester. Every forward is paired with an owner grant that names the forwarded cluster. A request that meets a busy directory or a writeback is always retried. The set of awaited acknowledgements only ever shrinks between loads. Other behaviour is visible only across sequences of requests, so the bench's scenarios have to show it: memory contents after forwarded reads and writebacks, the presence set left behind by a forward (exposed by a later invalidate mask), and the fact that stray acknowledgements and bad writebacks are ignored.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        LS_UNCACHED = 2'd0,
        LS_SHARED   = 2'd1,
        LS_MODIFIED = 2'd2
    } line_state_e;

    typedef enum logic {
        RQ_READ  = 1'b0,
        RQ_READX = 1'b1
    } req_kind_e;

    typedef enum logic {
        GK_DATA  = 1'b0,
        GK_OWNER = 1'b1
    } grant_kind_e;

    typedef enum logic [1:0] {
        MK_INV       = 2'd0,
        MK_FWD_READ  = 2'd1,
        MK_FWD_EXCL  = 2'd2
    } msg_kind_e;

    localparam logic [31:0] INIT_WORD_BASE = 32'hC0DE_0000;

endpackage

// File: rtl/dir_entry_table.sv
module dir_entry_table
    import dir_pkg::*;
#(
    parameter int NUM_LINES    = 16,
    parameter int NUM_CLUSTERS = 4,
    parameter int DATA_W       = 32,
    localparam int LW          = $clog2(NUM_LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LW-1:0]           a_line,
    output line_state_e             a_state,
    output logic [NUM_CLUSTERS-1:0] a_pres,
    output logic [DATA_W-1:0]       a_data,
    input  logic [LW-1:0]           b_line,
    output line_state_e             b_state,
    output logic [NUM_CLUSTERS-1:0] b_pres,
    output logic [DATA_W-1:0]       b_data,
    input  logic                    wr_en,
    input  logic [LW-1:0]           wr_line,
    input  line_state_e             wr_state,
    input  logic [NUM_CLUSTERS-1:0] wr_pres,
    input  logic                    wr_data_en,
    input  logic [DATA_W-1:0]       wr_data
);

    line_state_e             st_q [NUM_LINES];
    logic [NUM_CLUSTERS-1:0] pr_q [NUM_LINES];
    logic [DATA_W-1:0]       dt_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                st_q[i] <= LS_UNCACHED;
                pr_q[i] <= '0;
                dt_q[i] <= DATA_W'(INIT_WORD_BASE + 32'(i));
            end
        end else if (wr_en) begin
            st_q[wr_line] <= wr_state;
            pr_q[wr_line] <= wr_pres;
            if (wr_data_en) begin
                dt_q[wr_line] <= wr_data;
            end
        end
    end

    always_comb begin
        a_state = st_q[a_line];
        a_pres  = pr_q[a_line];
        a_data  = dt_q[a_line];
        b_state = st_q[b_line];
        b_pres  = pr_q[b_line];
        b_data  = dt_q[b_line];
    end

    // R3: a Modified line always has exactly one owner
    assert_modified_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == LS_MODIFIED) |-> $onehot(wr_pres));

    // R9: an Uncached line is held by nobody
    assert_uncached_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_state == LS_UNCACHED) |-> (wr_pres == '0));

endmodule

// File: rtl/dir_ack_collector.sv
module dir_ack_collector #(
    parameter int NUM_CLUSTERS = 4,
    localparam int IW          = $clog2(NUM_CLUSTERS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [NUM_CLUSTERS-1:0] load_mask,
    input  logic                    ack_valid,
    input  logic [IW-1:0]           ack_src,
    output logic                    busy,
    output logic                    done
);

    logic [NUM_CLUSTERS-1:0] pending_d, pending_q;
    logic [NUM_CLUSTERS-1:0] ack_bit;

    always_comb begin
        ack_bit   = ack_valid ? (NUM_CLUSTERS'(1) << ack_src) : '0;
        pending_d = load_en ? load_mask : (pending_q & ~ack_bit);
        busy      = |pending_q;
        done      = busy && !load_en && (pending_d == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else begin
            pending_q <= pending_d;
        end
    end

    // R4: a new wait set is only loaded when nothing is outstanding
    assert_load_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (pending_q == '0));

    // R11: without a load, the awaited set never gains a member
    assert_no_new_waiters_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ((pending_q & ~$past(pending_q)) == '0));

endmodule

// File: rtl/dir_home.sv
module dir_home
    import dir_pkg::*;
#(
    parameter int NUM_CLUSTERS = 4,
    parameter int NUM_LINES    = 16,
    parameter int DATA_W       = 32,
    localparam int IW          = $clog2(NUM_CLUSTERS),
    localparam int LW          = $clog2(NUM_LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_kind,
    input  logic [IW-1:0]           req_src,
    input  logic [LW-1:0]           req_line,
    input  logic                    ack_valid,
    input  logic [IW-1:0]           ack_src,
    input  logic [DATA_W-1:0]       ack_data,
    input  logic                    wb_valid,
    input  logic [IW-1:0]           wb_src,
    input  logic [LW-1:0]           wb_line,
    input  logic [DATA_W-1:0]       wb_data,
    output logic                    grant_valid,
    output logic                    grant_kind,
    output logic [IW-1:0]           grant_dst,
    output logic [IW-1:0]           grant_owner,
    output logic [DATA_W-1:0]       grant_data,
    output logic                    retry_valid,
    output logic [IW-1:0]           retry_dst,
    output logic                    msg_valid,
    output logic [1:0]              msg_kind,
    output logic [NUM_CLUSTERS-1:0] msg_mask,
    output logic [LW-1:0]           msg_line,
    output logic [IW-1:0]           msg_req
);

    typedef struct packed {
        logic [LW-1:0]           txn_line;
        msg_kind_e               txn_kind;
        logic [IW-1:0]           txn_req;
        logic [IW-1:0]           txn_owner;
        logic                    grant_valid;
        grant_kind_e             grant_kind;
        logic [IW-1:0]           grant_dst;
        logic [IW-1:0]           grant_owner;
        logic [DATA_W-1:0]       grant_data;
        logic                    retry_valid;
        logic [IW-1:0]           retry_dst;
        logic                    msg_valid;
        msg_kind_e               msg_kind;
        logic [NUM_CLUSTERS-1:0] msg_mask;
        logic [LW-1:0]           msg_line;
        logic [IW-1:0]           msg_req;
    } ctrl_t;

    ctrl_t s_d, s_q;

    line_state_e             a_state, b_state, wr_state;
    logic [NUM_CLUSTERS-1:0] a_pres, b_pres, wr_pres;
    logic [DATA_W-1:0]       a_data, b_data, wr_data;
    logic [LW-1:0]           b_line, wr_line;
    logic                    wr_en, wr_data_en;
    logic                    load_en, col_busy, col_done;
    logic [NUM_CLUSTERS-1:0] load_mask, req_bit, wb_bit;
    logic [IW-1:0]           owner_idx;

    assign b_line = col_busy ? s_q.txn_line : wb_line;

    dir_entry_table #(
        .NUM_LINES   (NUM_LINES),
        .NUM_CLUSTERS(NUM_CLUSTERS),
        .DATA_W      (DATA_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_line    (req_line),
        .a_state   (a_state),
        .a_pres    (a_pres),
        .a_data    (a_data),
        .b_line    (b_line),
        .b_state   (b_state),
        .b_pres    (b_pres),
        .b_data    (b_data),
        .wr_en     (wr_en),
        .wr_line   (wr_line),
        .wr_state  (wr_state),
        .wr_pres   (wr_pres),
        .wr_data_en(wr_data_en),
        .wr_data   (wr_data)
    );

    dir_ack_collector #(
        .NUM_CLUSTERS(NUM_CLUSTERS)
    ) u_acks (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_mask(load_mask),
        .ack_valid(ack_valid),
        .ack_src  (ack_src),
        .busy     (col_busy),
        .done     (col_done)
    );

    always_comb begin
        s_d             = s_q;
        s_d.grant_valid = 1'b0;
        s_d.retry_valid = 1'b0;
        s_d.msg_valid   = 1'b0;

        wr_en      = 1'b0;
        wr_line    = s_q.txn_line;
        wr_state   = LS_UNCACHED;
        wr_pres    = '0;
        wr_data_en = 1'b0;
        wr_data    = ack_data;
        load_en    = 1'b0;
        load_mask  = '0;

        req_bit = NUM_CLUSTERS'(1) << req_src;
        wb_bit  = NUM_CLUSTERS'(1) << wb_src;

        owner_idx = '0;
        for (int c = 0; c < NUM_CLUSTERS; c++) begin
            if (a_pres[c]) owner_idx = IW'(c);
        end

        // completion of the open transaction
        if (col_done) begin
            wr_en   = 1'b1;
            wr_line = s_q.txn_line;
            unique case (s_q.txn_kind)
                MK_INV: begin
                    wr_state        = LS_MODIFIED;
                    wr_pres         = NUM_CLUSTERS'(1) << s_q.txn_req;
                    s_d.grant_valid = 1'b1;
                    s_d.grant_kind  = GK_DATA;
                    s_d.grant_dst   = s_q.txn_req;
                    s_d.grant_owner = '0;
                    s_d.grant_data  = b_data;
                end
                MK_FWD_READ: begin
                    wr_state   = LS_SHARED;
                    wr_pres    = (NUM_CLUSTERS'(1) << s_q.txn_owner)
                               | (NUM_CLUSTERS'(1) << s_q.txn_req);
                    wr_data_en = 1'b1;
                    wr_data    = ack_data;
                end
                default: begin
                    wr_state = LS_MODIFIED;
                    wr_pres  = NUM_CLUSTERS'(1) << s_q.txn_req;
                end
            endcase
        end else if (wb_valid && !col_busy && b_state == LS_MODIFIED && b_pres == wb_bit) begin
            wr_en      = 1'b1;
            wr_line    = wb_line;
            wr_state   = LS_UNCACHED;
            wr_pres    = '0;
            wr_data_en = 1'b1;
            wr_data    = wb_data;
        end

        // new request
        if (req_valid) begin
            if (col_busy || wb_valid) begin
                s_d.retry_valid = 1'b1;
                s_d.retry_dst   = req_src;
            end else if (a_state == LS_MODIFIED) begin
                s_d.grant_valid = 1'b1;
                s_d.grant_kind  = GK_OWNER;
                s_d.grant_dst   = req_src;
                s_d.grant_owner = owner_idx;
                s_d.grant_data  = '0;
                if (owner_idx != req_src) begin
                    s_d.msg_valid = 1'b1;
                    s_d.msg_kind  = (req_kind == RQ_READ) ? MK_FWD_READ : MK_FWD_EXCL;
                    s_d.msg_mask  = a_pres;
                    s_d.msg_line  = req_line;
                    s_d.msg_req   = req_src;
                    load_en       = 1'b1;
                    load_mask     = a_pres;
                    s_d.txn_line  = req_line;
                    s_d.txn_kind  = (req_kind == RQ_READ) ? MK_FWD_READ : MK_FWD_EXCL;
                    s_d.txn_req   = req_src;
                    s_d.txn_owner = owner_idx;
                end
            end else if (req_kind == RQ_READ || (a_pres & ~req_bit) == '0) begin
                s_d.grant_valid = 1'b1;
                s_d.grant_kind  = GK_DATA;
                s_d.grant_dst   = req_src;
                s_d.grant_owner = '0;
                s_d.grant_data  = a_data;
                wr_en           = 1'b1;
                wr_line         = req_line;
                if (req_kind == RQ_READ) begin
                    wr_state = LS_SHARED;
                    wr_pres  = a_pres | req_bit;
                end else begin
                    wr_state = LS_MODIFIED;
                    wr_pres  = req_bit;
                end
            end else begin
                s_d.msg_valid = 1'b1;
                s_d.msg_kind  = MK_INV;
                s_d.msg_mask  = a_pres & ~req_bit;
                s_d.msg_line  = req_line;
                s_d.msg_req   = req_src;
                load_en       = 1'b1;
                load_mask     = a_pres & ~req_bit;
                s_d.txn_line  = req_line;
                s_d.txn_kind  = MK_INV;
                s_d.txn_req   = req_src;
                s_d.txn_owner = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_valid = s_q.grant_valid;
    assign grant_kind  = s_q.grant_kind;
    assign grant_dst   = s_q.grant_dst;
    assign grant_owner = s_q.grant_owner;
    assign grant_data  = s_q.grant_data;
    assign retry_valid = s_q.retry_valid;
    assign retry_dst   = s_q.retry_dst;
    assign msg_valid   = s_q.msg_valid;
    assign msg_kind    = s_q.msg_kind;
    assign msg_mask    = s_q.msg_mask;
    assign msg_line    = s_q.msg_line;
    assign msg_req     = s_q.msg_req;

    // R8: a request that meets an open transaction or a writeback is bounced
    assert_retry_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (col_busy || wb_valid)) |=> (retry_valid && retry_dst == $past(req_src)));

    // R4: invalidates never target the requester
    assert_inv_skips_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MK_INV) |-> !msg_mask[msg_req]);

    // R5: every forward travels with an owner grant naming the forwarded cluster
    assert_forward_pairs_owner_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind != MK_INV) |->
            (grant_valid && grant_kind == GK_OWNER
             && msg_mask == (NUM_CLUSTERS'(1) << grant_owner)));

endmodule

// File: tb/dir_home_bench.sv
`timescale 1ns/1ps
module dir_home_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_kind = 1'b0;
    logic [1:0]  req_src = '0;
    logic [3:0]  req_line = '0;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_src = '0;
    logic [31:0] ack_data = '0;
    logic        wb_valid = 1'b0;
    logic [1:0]  wb_src = '0;
    logic [3:0]  wb_line = '0;
    logic [31:0] wb_data = '0;
    logic        grant_valid, grant_kind, retry_valid, msg_valid;
    logic [1:0]  grant_dst, grant_owner, retry_dst, msg_req, msg_kind;
    logic [31:0] grant_data;
    logic [3:0]  msg_mask, msg_line;

    always #2.5 clk = ~clk;

    dir_home #(.NUM_CLUSTERS(4), .NUM_LINES(16), .DATA_W(32)) u_dir_home (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_src(req_src), .req_line(req_line),
        .ack_valid(ack_valid), .ack_src(ack_src), .ack_data(ack_data),
        .wb_valid(wb_valid), .wb_src(wb_src), .wb_line(wb_line), .wb_data(wb_data),
        .grant_valid(grant_valid), .grant_kind(grant_kind), .grant_dst(grant_dst),
        .grant_owner(grant_owner), .grant_data(grant_data),
        .retry_valid(retry_valid), .retry_dst(retry_dst),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_mask(msg_mask),
        .msg_line(msg_line), .msg_req(msg_req)
    );

    int          n_chk = 0;
    int          n_err = 0;
    bit          done_flag = 0;
    int          m_st [16];
    logic [3:0]  m_pr [16];
    logic [31:0] m_dt [16];
    logic [31:0] last_data;
    logic [1:0]  last_owner;
    logic [3:0]  last_mask;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int owner_of(input logic [3:0] p);
        int o = 0;
        for (int c = 0; c < 4; c++) if (p[c]) o = c;
        return o;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        req_valid = 0; ack_valid = 0; wb_valid = 0;
    endtask

    // drive an unrelated request during an ack cycle; it must be retried
    task automatic side_req(input bit inject, output int isrc);
        isrc = $urandom % 4;
        req_valid = inject;
        req_kind  = 1'($urandom);
        req_src   = isrc[1:0];
        req_line  = 4'($urandom);
    endtask

    task automatic run_req(input bit kind, input int src, input int line, input bit inject);
        logic [3:0]  sb = 4'(1 << src);
        logic [3:0]  pr = m_pr[line];
        logic [3:0]  others, remain;
        int          st = m_st[line];
        int          ow, isrc;
        logic [31:0] nd;
        @(negedge clk);
        req_valid = 1; req_kind = kind; req_src = src[1:0]; req_line = line[3:0];
        step();
        last_data = grant_data; last_owner = grant_owner; last_mask = msg_mask;
        if (st == 2) begin
            ow = owner_of(pr);
            chk(grant_valid && grant_kind && grant_owner == ow[1:0] && grant_dst == src[1:0],
                (ow == src) ? "R12 owner grant" : "R5 owner grant", {grant_valid, grant_kind, grant_owner}, {1'b1, 1'b1, ow[1:0]});
            if (ow == src) begin
                chk(!msg_valid, "R12 no message", msg_valid, 0);
            end else begin
                chk(msg_valid && msg_kind == (kind ? 2'd2 : 2'd1) && msg_mask == 4'(1 << ow)
                    && msg_req == src[1:0] && msg_line == line[3:0],
                    "R5 forward message", {msg_valid, msg_kind, msg_mask, msg_req}, {1'b1, (kind ? 2'd2 : 2'd1), 4'(1 << ow), src[1:0]});
                nd = $urandom;
                @(negedge clk);
                ack_valid = 1; ack_src = ow[1:0]; ack_data = nd;
                side_req(inject, isrc);
                step();
                chk(!grant_valid, kind ? "R7 no grant at completion" : "R6 no grant at completion", grant_valid, 0);
                if (inject) chk(retry_valid && retry_dst == isrc[1:0], "R8 retry during forward", retry_dst, isrc);
                if (kind) begin
                    m_pr[line] = sb;
                end else begin
                    m_st[line] = 1; m_pr[line] = sb | 4'(1 << ow); m_dt[line] = nd;
                end
            end
        end else if (kind == 0 || (pr & ~sb) == 0) begin
            chk(grant_valid && !grant_kind && grant_dst == src[1:0] && grant_data == m_dt[line] && !msg_valid,
                kind ? "R3 exclusive data grant" : "R2 read data grant", {grant_valid, grant_data}, {1'b1, m_dt[line]});
            if (kind) begin m_st[line] = 2; m_pr[line] = sb; end
            else      begin m_st[line] = 1; m_pr[line] = pr | sb; end
        end else begin
            others = pr & ~sb;
            chk(msg_valid && msg_kind == 0 && msg_mask == others && msg_req == src[1:0] && !grant_valid,
                "R4 invalidate message", {msg_valid, msg_kind, msg_mask, grant_valid}, {1'b1, 2'd0, others, 1'b0});
            @(negedge clk);
            req_valid = 0; ack_valid = 1; ack_src = src[1:0];
            step();
            chk(!grant_valid, "R11 stray ack ignored", grant_valid, 0);
            remain = others;
            for (int c = 0; c < 4; c++) begin
                if (others[c]) begin
                    @(negedge clk);
                    ack_valid = 1; ack_src = 2'(c);
                    side_req(inject, isrc);
                    step();
                    remain[c] = 1'b0;
                    if (remain == 0)
                        chk(grant_valid && !grant_kind && grant_dst == src[1:0] && grant_data == m_dt[line],
                            "R4 grant after last ack", {grant_valid, grant_data}, {1'b1, m_dt[line]});
                    else
                        chk(!grant_valid, "R4 no grant before last ack", grant_valid, 0);
                    if (inject) chk(retry_valid && retry_dst == isrc[1:0], "R8 retry during invalidate", retry_dst, isrc);
                end
            end
            last_data = grant_data;
            m_st[line] = 2; m_pr[line] = sb;
        end
        idle_inputs();
    endtask

    task automatic run_wb(input int src, input int line, input logic [31:0] d);
        bit takes = (m_st[line] == 2) && (owner_of(m_pr[line]) == src);
        @(negedge clk);
        wb_valid = 1; wb_src = src[1:0]; wb_line = line[3:0]; wb_data = d;
        step();
        chk(!grant_valid && !msg_valid && !retry_valid, takes ? "R9 writeback silent" : "R10 writeback silent",
            {grant_valid, msg_valid, retry_valid}, 0);
        if (takes) begin m_st[line] = 0; m_pr[line] = 0; m_dt[line] = d; end
        idle_inputs();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1234_5678);
        for (int i = 0; i < 16; i++) begin
            m_st[i] = 0; m_pr[i] = 0; m_dt[i] = 32'hC0DE_0000 + 32'(i);
        end
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        step();
        chk(!grant_valid && !retry_valid && !msg_valid, "R1 outputs idle after reset",
            {grant_valid, retry_valid, msg_valid}, 0);

        // R1/R2: initial contents
        run_req(0, 0, 0, 0);
        chk(last_data == 32'hC0DE_0000, "R1 initial word", last_data, 32'hC0DE_0000);
        run_req(0, 2, 7, 0);
        chk(last_data == 32'hC0DE_0007, "R1 initial word line 7", last_data, 32'hC0DE_0007);

        // R3 then R12
        run_req(1, 1, 3, 0);
        run_req(1, 1, 3, 0);
        chk(last_owner == 2'd1, "R12 names itself", last_owner, 1);

        // R5/R6: forwarded read, then observe data and presence
        run_req(0, 2, 3, 1);
        run_req(0, 3, 3, 0);
        chk(last_data == m_dt[3], "R6 owner data stored", last_data, m_dt[3]);
        run_req(1, 0, 3, 1);
        chk(last_mask == 4'b1110, "R6 both clusters marked", last_mask, 4'b1110);

        // R7: forwarded exclusive moves ownership
        run_req(1, 2, 3, 0);
        run_req(0, 1, 3, 0);
        chk(last_owner == 2'd2, "R7 new owner named", last_owner, 2);
        // the previous read opened a forward to 2; line now Shared by 1 and 2
        run_req(1, 2, 3, 0);

        // R10: writeback by non-owner, and to a Shared line
        run_wb(1, 3, 32'hDEAD_0001);
        run_req(1, 2, 3, 0);
        chk(last_owner == 2'd2, "R10 owner unchanged", last_owner, 2);
        run_wb(0, 0, 32'hDEAD_0002);
        run_req(0, 1, 0, 0);
        chk(last_data == 32'hC0DE_0000, "R10 shared line data kept", last_data, 32'hC0DE_0000);

        // R9: owner writeback returns the line to memory
        run_wb(2, 3, 32'h1234_ABCD);
        run_req(1, 0, 3, 0);
        chk(last_data == 32'h1234_ABCD, "R9 writeback data", last_data, 32'h1234_ABCD);

        // R8: request together with a writeback
        @(negedge clk);
        wb_valid = 1; wb_src = 3; wb_line = 9; wb_data = 32'hBAD0_0009;
        req_valid = 1; req_kind = 0; req_src = 1; req_line = 9;
        step();
        chk(retry_valid && retry_dst == 2'd1 && !grant_valid, "R8 retry with writeback",
            {retry_valid, retry_dst, grant_valid}, {1'b1, 2'd1, 1'b0});
        idle_inputs();
        run_req(1, 1, 9, 0);
        chk(last_data == 32'hC0DE_0009, "R8 line unchanged after retry", last_data, 32'hC0DE_0009);

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int line = $urandom % 8;
            if ($urandom % 5 == 0) begin
                int src = (m_st[line] == 2 && ($urandom % 2)) ? owner_of(m_pr[line]) : ($urandom % 4);
                run_wb(src, line, $urandom);
            end else begin
                run_req(1'($urandom), $urandom % 4, line, ($urandom % 3) == 0);
            end
        end

        finish_run();
    end

endmodule